// File: doc/BRIEF.md
# Floating-Point Exception Status Controller

This block holds the floating-point status and control word that sits beside an arithmetic unit. Software loads the word through a load strobe. Only the writable bits are kept. Two fields of the stored word are decoded into steering outputs: one selects the rounding behaviour and one selects flushing of denormal values.

Each time the arithmetic unit finishes an operation, it pulses a done strobe and presents five raw exception indications. The block replaces the per-operation flag field with those indications and merges them into a sticky cause field. If any cause bit is set together with its matching enable bit, it issues a one-cycle exception request that carries a fixed vector code. An operation that reports no exception only clears the flag field and never requests a trap.

Top module: `fp_status_ctl`

## Requirements
- R1: After reset the status word is zero, `trap_req` is 0, `trap_code` is 0, `round_zero` is 0 and `flush_denorm` is 0.
- R2: When `ld_en` is high, the status word takes `ld_data & 32'h0005_FFFF` on the next rising edge. Bit 17 and bits 31:19 always read 0.
- R3: `round_zero` is 1 exactly when status bits 1:0 equal 2'b01 (zero-rounding). The encodings 00, 10 and 11 give 0, which means round-to-nearest-even.
- R4: `flush_denorm` always equals status bit 18.
- R5: On `op_done`, the flag field (bits 6:2) is overwritten with `op_exc`. The bit order from low to high is inexact, underflow, overflow, divide-by-zero, invalid, so `op_exc[0]` goes to bit 2 and `op_exc[4]` goes to bit 6. Flag bits from earlier operations are cleared.
- R6: On `op_done`, the cause field (bits 16:12) becomes its old value ORed with `op_exc`, in the same bit order. No cause bit is ever cleared by an operation.
- R7: On the edge after `op_done`, `trap_req` goes to 1 for exactly one cycle when `op_exc` is nonzero and the updated cause ANDed with the enable field (bits 11:7) is nonzero. While `trap_req` is 1, `trap_code` is 12'h120; otherwise it is 0.
- R8: An operation with `op_exc` equal to 0 clears the flag field, leaves all other bits unchanged and raises no trap, even when stale cause bits match set enable bits.
- R9: When `ld_en` and `op_done` are high in the same cycle, the load wins, the operation is dropped and no trap is raised.
- R10: When an operation reports any exception, a cause bit left over from an earlier operation that matches a set enable bit also raises the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for the status word |
| ld_data | input | 32 | Value to load |
| op_done | input | 1 | Arithmetic operation completed |
| op_exc | input | 5 | Raw exceptions {V,Z,O,U,I}, bit 0 = inexact |
| status | output | 32 | Current status and control word |
| round_zero | output | 1 | 1 = round toward zero, 0 = nearest-even |
| flush_denorm | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle exception request |
| trap_code | output | 12 | Exception vector code, valid with `trap_req` |

## Verification
On every cycle, the assertions check the following:
- Unwritable bits stay zero.
- A load lands exactly as masked.
- No operation ever drops a cause bit.
- An exception-free operation leaves the control fields intact and raises no trap.
- Every trap request traces back to an unblocked operation that reported an exception.
- The vector code appears only with the request.

Only the directed scenarios can show the rest:
- The exact flag-to-bit mapping.
- That a trap is raised when one should be, including the case of a stale cause.
- The one-cycle width of the pulse.
- The load-over-operation priority.
- The rounding decode for each encoding.

// File: rtl/fp_status_ctl.sv
module fp_status_ctl #(
  parameter int          W         = 32,
  parameter int          NEXC      = 5,
  parameter int          FLAG_LSB  = 2,
  parameter int          EN_LSB    = 7,
  parameter int          CAUSE_LSB = 12,
  parameter int          DN_BIT    = 18,
  parameter int          VW        = 12,
  parameter logic [W-1:0]  WMASK   = 32'h0005_FFFF,
  parameter logic [VW-1:0] VEC     = 12'h120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [W-1:0]  ld_data,
  input  logic          op_done,
  input  logic [NEXC-1:0] op_exc,
  output logic [W-1:0]  status,
  output logic          round_zero,
  output logic          flush_denorm,
  output logic          trap_req,
  output logic [VW-1:0] trap_code
);

  localparam logic [1:0] RM_ZERO = 2'b01;

  logic [W-1:0]    st_q;
  logic            trap_q;
  logic [NEXC-1:0] en_f, cause_f, cause_nx;
  logic            hit;

  assign en_f     = st_q[EN_LSB +: NEXC];
  assign cause_f  = st_q[CAUSE_LSB +: NEXC];
  assign cause_nx = cause_f | op_exc;
  assign hit      = (|op_exc) && (|(cause_nx & en_f));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= 1'b0;
      if (ld_en) begin
        st_q <= ld_data & WMASK;
      end else if (op_done) begin
        st_q[FLAG_LSB +: NEXC]  <= op_exc;
        st_q[CAUSE_LSB +: NEXC] <= cause_nx;
        trap_q                  <= hit;
      end
    end
  end

  assign status       = st_q;
  assign round_zero   = (st_q[1:0] == RM_ZERO);
  assign flush_denorm = st_q[DN_BIT];
  assign trap_req     = trap_q;
  assign trap_code    = trap_q ? VEC : '0;

  // R2
  unwritable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~WMASK) == '0);

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> status == ($past(ld_data) & WMASK));

  // R6
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !ld_en) |=>
      ((status[CAUSE_LSB +: NEXC] & $past(status[CAUSE_LSB +: NEXC]))
        == $past(status[CAUSE_LSB +: NEXC])));

  // R8
  quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !ld_en && op_exc == '0) |=>
      (status[FLAG_LSB +: NEXC] == '0) && !trap_req &&
      $stable(status[W-1:FLAG_LSB+NEXC]) && $stable(status[FLAG_LSB-1:0]));

  // R7
  trap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(op_done && !ld_en && op_exc != '0));

  // R9
  load_blocks_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !trap_req);

  // R7
  code_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_code != '0) == trap_req);

endmodule

// File: tb/fp_status_ctl_tb.sv
`timescale 1ns/1ps
module fp_status_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_exc = '0;
  logic [31:0] status;
  logic        round_zero, flush_denorm, trap_req;
  logic [11:0] trap_code;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_st = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_status_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
    .op_done(op_done), .op_exc(op_exc), .status(status),
    .round_zero(round_zero), .flush_denorm(flush_denorm),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_trap(string req, bit exp_t);
    chk(req, {31'd0, trap_req}, {31'd0, exp_t});
    chk(req, {20'd0, trap_code}, exp_t ? 32'h120 : 32'h0);
  endtask

  task automatic load(logic [31:0] v);
    ld_en = 1'b1; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    exp_st = v & 32'h0005_FFFF;
  endtask

  task automatic op(logic [4:0] e, output bit exp_t);
    logic [4:0] c;
    op_done = 1'b1; op_exc = e;
    @(negedge clk);
    op_done = 1'b0; op_exc = '0;
    c = exp_st[16:12] | e;
    exp_t = (e != 0) && ((c & exp_st[11:7]) != 0);
    exp_st[6:2] = e;
    exp_st[16:12] = c;
  endtask

  task automatic t_reset;
    chk("R1 status", status, 32'h0);
    chk_trap("R1 trap", 1'b0);
    chk("R1 rz", {31'd0, round_zero}, 32'd0);
    chk("R1 dn", {31'd0, flush_denorm}, 32'd0);
  endtask

  task automatic t_load;
    load(32'hFFFF_FFFF);
    chk("R2 masked", status, 32'h0005_FFFF);
    chk("R3 rm=11", {31'd0, round_zero}, 32'd0);
    chk("R4 dn set", {31'd0, flush_denorm}, 32'd1);
    load(32'h0002_0001);
    chk("R2 bit17", status, 32'h0000_0001);
    chk("R3 rm=01", {31'd0, round_zero}, 32'd1);
    chk("R4 dn clr", {31'd0, flush_denorm}, 32'd0);
    load(32'h0000_0002);
    chk("R3 rm=10", {31'd0, round_zero}, 32'd0);
    load(32'h0000_0000);
    chk("R3 rm=00", {31'd0, round_zero}, 32'd0);
  endtask

  task automatic t_flags;
    bit t;
    load(32'h0);
    op(5'b00001, t);
    chk("R5 inexact flag", status, 32'h0000_1004);
    chk_trap("R6 no enable", 1'b0);
    op(5'b10000, t);
    chk("R5 replace flags", status, 32'h0001_1040);
    chk("R6 cause or", status, exp_st);
    op(5'b01110, t);
    chk("R6 accumulate", status, exp_st);
    chk("R5 flag mix", status[6:2], 32'(5'b01110));
  endtask

  task automatic t_quiet;
    bit t;
    load(32'h0005_0F83);
    op(5'b00000, t);
    chk("R8 quiet status", status, 32'h0005_0F83);
    chk_trap("R8 quiet trap", 1'b0);
    load(32'h0001_0800 | 32'h7C);
    op(5'b00000, t);
    chk("R8 flags cleared", status, 32'h0001_0800);
    chk_trap("R8 stale no trap", 1'b0);
  endtask

  task automatic t_trap;
    bit t;
    load(32'h0000_0400);
    op(5'b01000, t);
    chk_trap("R7 trap pulse", t);
    chk("R7 model", {31'd0, t}, 32'd1);
    chk("R7 status", status, 32'h0000_8420);
    @(negedge clk);
    chk_trap("R7 single cycle", 1'b0);
    op(5'b00100, t);
    chk_trap("R7 cause kept trap", 1'b1);
  endtask

  task automatic t_stale;
    bit t;
    load(32'h0001_0800);
    op(5'b00001, t);
    chk_trap("R10 stale cause trap", 1'b1);
    chk("R10 status", status, 32'h0001_1804);
  endtask

  task automatic t_collide;
    load(32'h0000_0F80);
    ld_en = 1'b1; ld_data = 32'h0000_0F81;
    op_done = 1'b1; op_exc = 5'b11111;
    @(negedge clk);
    ld_en = 1'b0; op_done = 1'b0; op_exc = '0;
    chk("R9 load wins", status, 32'h0000_0F81);
    chk_trap("R9 no trap", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_flags();
    t_quiet();
    t_trap();
    t_stale();
    t_collide();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule